// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers up to 32 single-cycle event pulses from neighbouring units into one latched status word and drives a single level-sensitive interrupt request toward the host. A status bit is set by its hardware event line, or by software writing a one into a separate injection register. Software clears a bit by writing a one to it in the status register. A mask register decides which latched bits may raise the request. A mask bit of 0 enables its source and a mask bit of 1 blocks it.

Software reaches the three registers through a simple word-wide register port. Writes take effect at the clock edge that samples the write strobe. Reads return their data, registered, in the cycle after the read strobe. Events are latched whatever the mask says. A host can therefore leave a source masked, poll its status bit, and later unmask it to turn a pending event into a request.

Top module: `irq_status_mask`

## Requirements
- R1: After reset the status word is all zeros, the mask word is all ones, `irqReq` is low and `busRdData` is zero.
- R2: The status register sits at byte offset 0x40, the injection register at 0x44 and the mask register at 0x48. A read strobe in one cycle puts the addressed value on `busRdData` in the next cycle, showing the state from before that edge. The injection register and every other offset read as zero, and `busRdData` is zero in any cycle that follows a cycle without a read strobe.
- R3: If `evtIn[k]` is high in a cycle, status bit k is 1 after that clock edge, whatever the value of mask bit k.
- R4: Writing to offset 0x44 sets every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R5: Writing to offset 0x40 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R6: When an event on line k arrives in the same cycle as a clear of bit k, the bit stays set.
- R7: Writing to offset 0x48 replaces the whole mask word with the write data.
- R8: `irqReq` is 1 exactly one cycle after a cycle in which (status AND NOT mask) is nonzero. It is 0 one cycle after that value becomes zero.
- R9: A set status bit stays set until software clears it. Changing the mask does not alter status.
- R10: Event line k maps to status bit k, with this fixed assignment: 31 encoder capture start, 30 encoder end of stream, 29 encoder VBI capture, 27 encoder DMA done, 22 decoder data request, 20 decoder DMA done, 18 DMA list fault.
- R11: A write to an unmapped or misaligned offset (for example 0x4C or 0x42) changes neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 32 | Event pulse lines, one per status bit |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 12 | Byte offset of the register access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqReq | output | 1 | Level interrupt request to the host |

## Verification
Every cycle, the assertions check the following: events are latched, bits are held until cleared, write-one-to-clear loses to a coinciding event, injection sets bits, the mask follows its write, the request stays low while nothing is enabled, and at most one register is selected per access. Some behaviours only the bench scenarios can show. These are the exact offset map and read-back values, the one-cycle request latency after an unmask or a clear, the fixed bit assignment, and that unmapped or misaligned writes leave both registers untouched. A behavioural model compared on every clock covers long random mixes of events and register traffic.

// File: rtl/irq_status_mask_pkg.sv
package irq_status_mask_pkg;

  typedef struct packed {
    logic wrStatus;
    logic wrSet;
    logic wrMask;
    logic rdStatus;
    logic rdMask;
    logic rdZero;
  } regStrb_t;

  localparam int BIT_ENC_CAP_START = 31;
  localparam int BIT_ENC_STREAM_END = 30;
  localparam int BIT_ENC_VBI = 29;
  localparam int BIT_ENC_DMA_DONE = 27;
  localparam int BIT_DEC_DATA_REQ = 22;
  localparam int BIT_DEC_DMA_DONE = 20;
  localparam int BIT_DMA_LIST_FAULT = 18;

endpackage

// File: rtl/irq_status_mask_ctrl.sv
module irq_status_mask_ctrl
  import irq_status_mask_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFF_STATUS = 'h40,
  parameter logic [ADDR_W-1:0] OFF_SET = 'h44,
  parameter logic [ADDR_W-1:0] OFF_MASK = 'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrb_t          strb
);

  logic hitStatus;
  logic hitSet;
  logic hitMask;

  always_comb begin
    hitStatus = (busAddr == OFF_STATUS);
    hitSet    = (busAddr == OFF_SET);
    hitMask   = (busAddr == OFF_MASK);
  end

  always_comb begin
    strb          = '0;
    strb.wrStatus = busWrEn & hitStatus;
    strb.wrSet    = busWrEn & hitSet;
    strb.wrMask   = busWrEn & hitMask;
    strb.rdStatus = busRdEn & hitStatus;
    strb.rdMask   = busRdEn & hitMask;
    strb.rdZero   = busRdEn & ~hitStatus & ~hitMask;
  end

  // R11
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrStatus, strb.wrSet, strb.wrMask}));

  // R2
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |-> $onehot({strb.rdStatus, strb.rdMask, strb.rdZero}));

endmodule

// File: rtl/irq_status_mask_bit.sv
module irq_status_mask_bit (
  input  logic clk,
  input  logic rstN,
  input  logic evt,
  input  logic setHit,
  input  logic clrHit,
  output logic q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= 1'b0;
    end else if (evt || setHit) begin
      q <= 1'b1;
    end else if (clrHit) begin
      q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_status_mask_regs.sv
module irq_status_mask_regs
  import irq_status_mask_pkg::*;
#(
  parameter int SRC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrb_t         strb,
  input  logic [SRC_W-1:0] evtIn,
  input  logic [SRC_W-1:0] wrData,
  output logic [SRC_W-1:0] rdData,
  output logic             irqReq
);

  logic [SRC_W-1:0] statusQ;
  logic [SRC_W-1:0] maskQ;
  logic [SRC_W-1:0] setVec;
  logic [SRC_W-1:0] clrVec;
  logic [SRC_W-1:0] rdNext;

  always_comb begin
    setVec = strb.wrSet ? wrData : '0;
    clrVec = strb.wrStatus ? wrData : '0;
  end

  for (genvar k = 0; k < SRC_W; k++) begin : g_stat
    irq_status_mask_bit u_bit (
      .clk   (clk),
      .rstN  (rstN),
      .evt   (evtIn[k]),
      .setHit(setVec[k]),
      .clrHit(clrVec[k]),
      .q     (statusQ[k])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
    end else if (strb.wrMask) begin
      maskQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
    end else begin
      irqReq <= |(statusQ & ~maskQ);
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdStatus) rdNext = statusQ;
    else if (strb.rdMask) rdNext = maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      rdData <= rdNext;
    end
  end

  // R3
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((statusQ & $past(evtIn)) == $past(evtIn)));

  // R4
  set_inject_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> ((statusQ & $past(wrData)) == $past(wrData)));

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStatus |=> ((statusQ & $past(wrData & ~evtIn)) == '0));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |=> (maskQ == $past(wrData)));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~maskQ) == '0) |=> !irqReq);

endmodule

// File: rtl/irq_status_mask.sv
module irq_status_mask
  import irq_status_mask_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_W-1:0]  evtIn,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SRC_W-1:0]  busWrData,
  output logic [SRC_W-1:0]  busRdData,
  output logic              irqReq
);

  regStrb_t strb;

  irq_status_mask_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .strb   (strb)
  );

  irq_status_mask_regs #(
    .SRC_W(SRC_W)
  ) u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .evtIn (evtIn),
    .wrData(busWrData),
    .rdData(busRdData),
    .irqReq(irqReq)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqReq && busRdData == '0));

endmodule

// File: tb/irq_status_mask_test.sv
module irq_status_mask_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtIn = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqReq;

  int total = 0;
  int bad = 0;
  bit cmpOn = 1'b0;
  bit [31:0] mStatus, mMask, mRd;
  bit mIrq;

  always #2 clk = ~clk;

  irq_status_mask uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irqReq(irqReq)
  );

  // behavioural reference, updated from pre-edge values
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStatus = 0; mMask = '1; mIrq = 0; mRd = 0;
    end else begin
      bit [31:0] s, m, r;
      s = mStatus; m = mMask; r = 0;
      if (busRdEn) begin
        if (busAddr == 12'h040) r = mStatus;
        else if (busAddr == 12'h048) r = mMask;
      end
      mIrq = ((mStatus & ~mMask) != 0);
      if (busWrEn && busAddr == 12'h040) s = s & ~busWrData;
      if (busWrEn && busAddr == 12'h044) s = s | busWrData;
      if (busWrEn && busAddr == 12'h048) m = busWrData;
      s = s | evtIn;
      mStatus = s; mMask = m; mRd = r;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      check("R8 irqReq vs model", {31'b0, irqReq}, {31'b0, mIrq});
      check("R2 busRdData vs model", busRdData, mRd);
    end
  end

  task automatic step(logic [31:0] evt, logic wr, logic rd, logic [11:0] addr, logic [31:0] data);
    evtIn = evt; busWrEn = wr; busRdEn = rd; busAddr = addr; busWrData = data;
    @(negedge clk);
    evtIn = '0; busWrEn = 0; busRdEn = 0; busAddr = '0; busWrData = '0;
  endtask

  task automatic rd(logic [11:0] addr, output logic [31:0] d);
    step('0, 0, 1, addr, '0);
    d = busRdData;
  endtask

  task automatic wr(logic [11:0] addr, logic [31:0] d);
    step('0, 1, 0, addr, d);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;
    // R1 reset state
    check("R1 irq after reset", {31'b0, irqReq}, 32'h0);
    rd(12'h040, d); check("R1 status after reset", d, 32'h0);
    rd(12'h048, d); check("R1 mask after reset", d, 32'hFFFF_FFFF);
    // R3 / R10 masked event still latches
    step(32'h1 << 27, 0, 0, '0, '0);
    rd(12'h040, d); check("R10 encoder DMA done at bit 27", d, 32'h0800_0000);
    check("R3 masked latch keeps irq low", {31'b0, irqReq}, 32'h0);
    // R7 / R8 unmask
    wr(12'h048, ~(32'h1 << 27));
    check("R8 irq still low right after unmask", {31'b0, irqReq}, 32'h0);
    step('0, 0, 0, '0, '0);
    check("R8 irq high one cycle later", {31'b0, irqReq}, 32'h1);
    rd(12'h048, d); check("R7 mask readback", d, 32'hF7FF_FFFF);
    // R5 clear
    wr(12'h040, 32'h0800_0000);
    check("R8 irq one cycle after clear still high", {31'b0, irqReq}, 32'h1);
    rd(12'h040, d); check("R5 status cleared", d, 32'h0);
    check("R8 irq dropped", {31'b0, irqReq}, 32'h0);
    // R4 injection, injection register reads zero
    wr(12'h044, 32'h0014_0000);
    rd(12'h040, d); check("R4 injected bits", d, 32'h0014_0000);
    rd(12'h044, d); check("R2 set register reads zero", d, 32'h0);
    // R6 event beats clear
    step(32'h1 << 20, 1, 0, 12'h040, 32'h0014_0000);
    rd(12'h040, d); check("R6 event wins over clear", d, 32'h0010_0000);
    // R9 masking does not clear
    wr(12'h048, 32'h0);
    wr(12'h048, 32'hFFFF_FFFF);
    rd(12'h040, d); check("R9 status kept across mask change", d, 32'h0010_0000);
    // R11 unmapped / misaligned writes
    wr(12'h04C, 32'h0);
    wr(12'h042, 32'hFFFF_FFFF);
    wr(12'h049, 32'h0);
    rd(12'h040, d); check("R11 status untouched", d, 32'h0010_0000);
    rd(12'h048, d); check("R11 mask untouched", d, 32'hFFFF_FFFF);
    rd(12'h04C, d); check("R2 unmapped reads zero", d, 32'h0);
    // R10 remaining assignments
    step((32'h1 << 31) | (32'h1 << 30) | (32'h1 << 29) | (32'h1 << 22), 0, 0, '0, '0);
    rd(12'h040, d); check("R10 fixed bit map", d, 32'hE050_0000);
    // random traffic compared against the model every cycle (R2, R3, R4, R5, R8)
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [31:0] e;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = 12'h040; 1: a = 12'h044; 2: a = 12'h048;
        3: a = 12'h04C; 4: a = 12'h042; default: a = 12'h000;
      endcase
      e = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0;
      step(e, $urandom_range(0, 1), $urandom_range(0, 1), a, $urandom());
    end
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule